// File: doc/BRIEF.md
# Lookup-Table Duty Ramp Sequencer

This block produces slowly changing duty values for a pulse-width modulator, so that a light can breathe, fade or blink without software involvement. A 64-entry table of 9-bit duty values is loaded through a two-register write port. The sequencer then walks a window of that table, bounded by a low and a high entry index. It holds each entry for a programmable number of 1 kHz ticks and can linger longer at either end of the window. The current entry's value is presented on the duty output, and the PWM counter downstream consumes it.

The walk can begin at the bottom of the window and climb, or begin at the top and descend. At the far end it either jumps back to its starting entry or turns around and walks back. Repetition can be enabled so that the pattern never ends. Without it, the sequencer stops on the last entry and raises a done flag. Step dwell and end pauses are chosen by short codes that index fixed, non-linear time tables. The sequencer runs only while both a generator enable and a go bit are held high. Dropping either one returns the block to idle, and raising them again restarts the pattern from its beginning.

Top module: `lut_ramp_seq`

## Requirements
- R1: A write to the first table register (tbl_lo_we) stages an 8-bit value. A write to the second register (tbl_hi_we) commits entry tbl_entry_idx with tbl_val_msb as value bit 8 and the staged byte as bits 7:0. Every entry is 0 after reset.
- R2: A write to the first table register alone changes no table entry.
- R3: While gen_en and ramp_go are not both high, the block is idle, with duty 0, running 0 and done 0. The cycle after both are high in idle, running is 1 and duty shows the starting entry.
- R4: The step code selects a dwell of 0,1,2,3,4,6,8,16,18,24,32,36,64,128,256,512 ticks for codes 0 to 15. Code 0 behaves as 1 tick. An entry is left on the tick that completes its dwell.
- R5: With ramp_up=1 the walk starts at lo_idx and moves up by one entry per dwell. With ramp_up=0 it starts at the effective high index and moves down.
- R6: With reverse_en=1 the walk turns around at the far end, steps one entry back toward its start, and ends a pass on reaching the starting entry.
- R7: With loop_en=1 the pattern repeats without end. Without reverse it jumps back to the starting entry. With reverse it turns around again at the starting end.
- R8: When an end's pause enable is set, the entry at that end is held for an extra (pause value x dwell) ticks after its dwell. The high-end pause applies when the end is reached while moving up, and the low-end pause when it is reached while moving down.
- R9: Pause codes 0 to 56 select 1..16, 23, 28, 31, 42, 47, 56, 63, 83, 94, 111, 125, 167, 188, 222, 250, 333, 375, 500, 667, 750, 800, 900, 1000..1600 in steps of 100, 1800, 2000 and 2500..7000 in steps of 500. Codes above 56 saturate to 7000.
- R10: With loop_en=0, once the pattern ends the block holds the final entry's value with done=1 and running=0 until the run condition is removed.
- R11: If lo_idx exceeds hi_idx, the window is the single entry at lo_idx.
- R12: A table commit that lands in the same cycle as a step shows its new value at once if the walk steps onto that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1k | input | 1 | One-cycle pulse per millisecond |
| tbl_lo_we | input | 1 | Write strobe, first table register |
| tbl_lo_data | input | 8 | Value bits 7:0 |
| tbl_hi_we | input | 1 | Write strobe, second table register (commits) |
| tbl_val_msb | input | 1 | Value bit 8 |
| tbl_entry_idx | input | 6 | Table entry being written |
| gen_en | input | 1 | Ramp generator enable |
| ramp_go | input | 1 | Ramp start |
| ramp_up | input | 1 | 1: start low and climb; 0: start high and descend |
| reverse_en | input | 1 | Turn around at the far end |
| loop_en | input | 1 | Repeat the pattern |
| lo_idx | input | 6 | Low window index |
| hi_idx | input | 6 | High window index |
| step_code | input | 4 | Dwell code |
| pause_hi_en | input | 1 | Enable high-end pause |
| pause_hi_code | input | 6 | High-end pause code |
| pause_lo_en | input | 1 | Enable low-end pause |
| pause_lo_code | input | 6 | Low-end pause code |
| duty | output | 9 | Current duty value |
| running | output | 1 | Walk or pause in progress |
| done | output | 1 | Single-shot pattern complete |

## Verification
A table commit and a step of the walker can fall in the same clock edge. The interesting case is a commit that rewrites the very entry the walker is about to move onto. The bench provokes this by raising the commit strobe together with a tick that ends the current dwell. It judges the result by requiring that the duty sampled after that edge equals the freshly written value, not the old one. Randomized patterns also interleave end pauses with turnarounds, and their per-tick duty, running and done values are compared against a sequence built from the requirements.

// File: rtl/lut_ramp_pkg.sv
package lut_ramp_pkg;

   localparam int STEP_CODE_W  = 4;
   localparam int PAUSE_CODE_W = 6;
   localparam int DWELL_W      = 10;
   localparam int REPS_W       = 13;
   localparam int VAL_W        = 9;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_STEP  = 2'd1,
      ST_PAUSE = 2'd2,
      ST_DONE  = 2'd3
   } seq_state_t;

   // dwell per entry in ticks; code 0 is promoted to a single tick
   function automatic logic [DWELL_W-1:0] dwell_ticks(input logic [STEP_CODE_W-1:0] code);
      logic [DWELL_W-1:0] t;
      case (code)
         4'd0:  t = 10'd1;
         4'd1:  t = 10'd1;
         4'd2:  t = 10'd2;
         4'd3:  t = 10'd3;
         4'd4:  t = 10'd4;
         4'd5:  t = 10'd6;
         4'd6:  t = 10'd8;
         4'd7:  t = 10'd16;
         4'd8:  t = 10'd18;
         4'd9:  t = 10'd24;
         4'd10: t = 10'd32;
         4'd11: t = 10'd36;
         4'd12: t = 10'd64;
         4'd13: t = 10'd128;
         4'd14: t = 10'd256;
         default: t = 10'd512;
      endcase
      return t;
   endfunction

   // pause length in units of one dwell
   function automatic logic [REPS_W-1:0] pause_reps(input logic [PAUSE_CODE_W-1:0] code);
      logic [REPS_W-1:0] r;
      if (code < 6'd16) begin
         r = REPS_W'(code) + 13'd1;
      end else if (code >= 6'd56) begin
         r = 13'd7000;
      end else if (code >= 6'd48) begin
         r = 13'd3000 + 13'd500 * REPS_W'(code - 6'd48);
      end else if (code >= 6'd37) begin
         case (code)
            6'd37: r = 13'd900;
            6'd45: r = 13'd1800;
            6'd46: r = 13'd2000;
            6'd47: r = 13'd2500;
            default: r = 13'd1000 + 13'd100 * REPS_W'(code - 6'd38);
         endcase
      end else begin
         case (code)
            6'd16: r = 13'd23;   6'd17: r = 13'd28;   6'd18: r = 13'd31;
            6'd19: r = 13'd42;   6'd20: r = 13'd47;   6'd21: r = 13'd56;
            6'd22: r = 13'd63;   6'd23: r = 13'd83;   6'd24: r = 13'd94;
            6'd25: r = 13'd111;  6'd26: r = 13'd125;  6'd27: r = 13'd167;
            6'd28: r = 13'd188;  6'd29: r = 13'd222;  6'd30: r = 13'd250;
            6'd31: r = 13'd333;  6'd32: r = 13'd375;  6'd33: r = 13'd500;
            6'd34: r = 13'd667;  6'd35: r = 13'd750;
            default: r = 13'd800;
         endcase
      end
      return r;
   endfunction

endpackage

// File: rtl/lut_ramp_table.sv
module lut_ramp_table
   import lut_ramp_pkg::*;
#(
   parameter int IDX_W       = 6,
   parameter bit RESET_TABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lo_we,
   input  logic [7:0]       lo_data,
   input  logic             hi_we,
   input  logic             val_msb,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [VAL_W-1:0] rd_val
);
   localparam int DEPTH = 1 << IDX_W;

   logic [7:0]       stage_q;
   logic [VAL_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else if (lo_we) stage_q <= lo_data;
   end

   generate
      if (RESET_TABLE) begin : g_rst_mem
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            end else if (hi_we) begin
               mem_q[wr_idx] <= {val_msb, stage_q};
            end
         end
      end else begin : g_plain_mem
         always_ff @(posedge clk) begin
            if (hi_we) mem_q[wr_idx] <= {val_msb, stage_q};
         end
      end
   endgenerate

   assign rd_val = mem_q[rd_idx];
endmodule

// File: rtl/lut_ramp_timer.sv
module lut_ramp_timer
   import lut_ramp_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               tick,
   input  logic [DWELL_W-1:0] len,
   output logic               expire
);
   logic [DWELL_W-1:0] cnt_q;
   logic               last;

   assign last   = (cnt_q >= len - DWELL_W'(1));
   assign expire = tick & ~clr & last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr)    cnt_q <= '0;
      else if (tick)   cnt_q <= last ? '0 : cnt_q + DWELL_W'(1);
   end
endmodule

// File: rtl/lut_ramp_walker.sv
module lut_ramp_walker
   import lut_ramp_pkg::*;
#(
   parameter int IDX_W = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run,
   input  logic                    expire,
   input  logic                    ramp_up,
   input  logic                    reverse_en,
   input  logic                    loop_en,
   input  logic [IDX_W-1:0]        lo_idx,
   input  logic [IDX_W-1:0]        hi_idx,
   input  logic                    pause_hi_en,
   input  logic [PAUSE_CODE_W-1:0] pause_hi_code,
   input  logic                    pause_lo_en,
   input  logic [PAUSE_CODE_W-1:0] pause_lo_code,
   output seq_state_t              state,
   output logic [IDX_W-1:0]        cur_idx
);
   logic              dir_up_q;
   logic [REPS_W-1:0] rep_q;
   logic [IDX_W-1:0]  hi_eff, start_idx, inward_idx, wrap_idx;
   logic              single, at_end, end_pause_en, pause_last;
   logic              turn, wrap_dir, wrap_done;
   logic [REPS_W-1:0] end_reps;

   assign hi_eff     = (lo_idx > hi_idx) ? lo_idx : hi_idx;
   assign single     = (hi_eff == lo_idx);
   assign start_idx  = ramp_up ? lo_idx : hi_eff;
   assign at_end     = dir_up_q ? (cur_idx >= hi_eff) : (cur_idx <= lo_idx);
   assign end_pause_en = dir_up_q ? pause_hi_en : pause_lo_en;
   assign end_reps   = dir_up_q ? pause_reps(pause_hi_code) : pause_reps(pause_lo_code);
   assign pause_last = (rep_q >= end_reps - REPS_W'(1));
   assign inward_idx = dir_up_q ? cur_idx - IDX_W'(1) : cur_idx + IDX_W'(1);

   // action at the end of a pass: turn around, restart, or finish
   assign turn      = reverse_en & ~single & ((dir_up_q == ramp_up) | loop_en);
   assign wrap_idx  = turn ? inward_idx : start_idx;
   assign wrap_dir  = turn ? ~dir_up_q : ramp_up;
   assign wrap_done = ~turn & ~loop_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cur_idx  <= '0;
         dir_up_q <= 1'b1;
         rep_q    <= '0;
      end else if (!run) begin
         state <= ST_IDLE;
      end else begin
         case (state)
            ST_IDLE: begin
               state    <= ST_STEP;
               cur_idx  <= start_idx;
               dir_up_q <= ramp_up;
               rep_q    <= '0;
            end
            ST_STEP: if (expire) begin
               if (!at_end) begin
                  cur_idx <= dir_up_q ? cur_idx + IDX_W'(1) : cur_idx - IDX_W'(1);
               end else if (end_pause_en) begin
                  state <= ST_PAUSE;
                  rep_q <= '0;
               end else if (wrap_done) begin
                  state <= ST_DONE;
               end else begin
                  cur_idx  <= wrap_idx;
                  dir_up_q <= wrap_dir;
               end
            end
            ST_PAUSE: if (expire) begin
               if (!pause_last) begin
                  rep_q <= rep_q + REPS_W'(1);
               end else if (wrap_done) begin
                  state <= ST_DONE;
               end else begin
                  state    <= ST_STEP;
                  cur_idx  <= wrap_idx;
                  dir_up_q <= wrap_dir;
               end
            end
            default: state <= ST_DONE;
         endcase
      end
   end
endmodule

// File: rtl/lut_ramp_seq.sv
module lut_ramp_seq
   import lut_ramp_pkg::*;
#(
   parameter int IDX_W       = 6,
   parameter bit RESET_TABLE = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick_1k,
   input  logic                    tbl_lo_we,
   input  logic [7:0]              tbl_lo_data,
   input  logic                    tbl_hi_we,
   input  logic                    tbl_val_msb,
   input  logic [IDX_W-1:0]        tbl_entry_idx,
   input  logic                    gen_en,
   input  logic                    ramp_go,
   input  logic                    ramp_up,
   input  logic                    reverse_en,
   input  logic                    loop_en,
   input  logic [IDX_W-1:0]        lo_idx,
   input  logic [IDX_W-1:0]        hi_idx,
   input  logic [STEP_CODE_W-1:0]  step_code,
   input  logic                    pause_hi_en,
   input  logic [PAUSE_CODE_W-1:0] pause_hi_code,
   input  logic                    pause_lo_en,
   input  logic [PAUSE_CODE_W-1:0] pause_lo_code,
   output logic [VAL_W-1:0]        duty,
   output logic                    running,
   output logic                    done
);
   generate
      if (IDX_W < 1 || IDX_W > 7) begin : g_bad_idx_w
         $error("lut_ramp_seq: IDX_W must lie in 1..7");
      end
   endgenerate

   seq_state_t       state;
   logic [IDX_W-1:0] cur_idx;
   logic [VAL_W-1:0] rd_val;
   logic             run, expire;

   assign run = gen_en & ramp_go;

   lut_ramp_table #(.IDX_W(IDX_W), .RESET_TABLE(RESET_TABLE)) table_i (
      .clk(clk), .rst_n(rst_n),
      .lo_we(tbl_lo_we), .lo_data(tbl_lo_data),
      .hi_we(tbl_hi_we), .val_msb(tbl_val_msb), .wr_idx(tbl_entry_idx),
      .rd_idx(cur_idx), .rd_val(rd_val)
   );

   lut_ramp_timer timer_i (
      .clk(clk), .rst_n(rst_n),
      .clr(state == ST_IDLE), .tick(tick_1k),
      .len(dwell_ticks(step_code)), .expire(expire)
   );

   lut_ramp_walker #(.IDX_W(IDX_W)) walker_i (
      .clk(clk), .rst_n(rst_n), .run(run), .expire(expire),
      .ramp_up(ramp_up), .reverse_en(reverse_en), .loop_en(loop_en),
      .lo_idx(lo_idx), .hi_idx(hi_idx),
      .pause_hi_en(pause_hi_en), .pause_hi_code(pause_hi_code),
      .pause_lo_en(pause_lo_en), .pause_lo_code(pause_lo_code),
      .state(state), .cur_idx(cur_idx)
   );

   assign duty    = (state == ST_IDLE) ? '0 : rd_val;
   assign running = (state == ST_STEP) || (state == ST_PAUSE);
   assign done    = (state == ST_DONE);
endmodule

// File: rtl/lut_ramp_seq_chk.sv
module lut_ramp_seq_chk #(
   parameter int IDX_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_1k,
   input logic             gen_en,
   input logic             ramp_go,
   input logic             running,
   input logic             done,
   input logic [8:0]       duty,
   input logic [IDX_W-1:0] cur_idx
);
   p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(gen_en && ramp_go) |=> (!running && !done && duty == 9'd0));

   p_start_runs_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !done && gen_en && ramp_go) |=> running);

   p_step_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (running && gen_en && ramp_go && !tick_1k) |=> $stable(cur_idx));

   p_done_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && gen_en && ramp_go) |=> (done && $stable(cur_idx)));

   p_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && running));
endmodule

bind lut_ramp_seq lut_ramp_seq_chk #(.IDX_W(IDX_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .tick_1k(tick_1k), .gen_en(gen_en),
   .ramp_go(ramp_go), .running(running), .done(done), .duty(duty),
   .cur_idx(cur_idx)
);

// File: tb/lut_ramp_seq_tb_top.sv
module lut_ramp_seq_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1k = 1'b0;
   logic       tbl_lo_we = 1'b0;
   logic [7:0] tbl_lo_data = '0;
   logic       tbl_hi_we = 1'b0;
   logic       tbl_val_msb = 1'b0;
   logic [5:0] tbl_entry_idx = '0;
   logic       gen_en = 1'b0, ramp_go = 1'b0, ramp_up = 1'b1;
   logic       reverse_en = 1'b0, loop_en = 1'b0;
   logic [5:0] lo_idx = '0, hi_idx = '0;
   logic [3:0] step_code = '0;
   logic       pause_hi_en = 1'b0, pause_lo_en = 1'b0;
   logic [5:0] pause_hi_code = '0, pause_lo_code = '0;
   logic [8:0] duty;
   logic       running, done;

   int n_checks = 0;
   int n_errors = 0;
   int cycles   = 0;
   int exp_mem [64];
   int seq_q [$];

   localparam int STEP_T [16] = '{1,1,2,3,4,6,8,16,18,24,32,36,64,128,256,512};
   localparam int PAUSE_T [57] = '{
      1,2,3,4,5,6,7,8,9,10,11,12,13,14,15,16,
      23,28,31,42,47,56,63,83,94,111,125,167,188,222,250,333,
      375,500,667,750,800,900,1000,1100,1200,1300,1400,1500,1600,1800,2000,2500,
      3000,3500,4000,4500,5000,5500,6000,6500,7000};

   lut_ramp_seq dut_i (
      .clk(clk), .rst_n(rst_n), .tick_1k(tick_1k),
      .tbl_lo_we(tbl_lo_we), .tbl_lo_data(tbl_lo_data),
      .tbl_hi_we(tbl_hi_we), .tbl_val_msb(tbl_val_msb), .tbl_entry_idx(tbl_entry_idx),
      .gen_en(gen_en), .ramp_go(ramp_go), .ramp_up(ramp_up),
      .reverse_en(reverse_en), .loop_en(loop_en),
      .lo_idx(lo_idx), .hi_idx(hi_idx), .step_code(step_code),
      .pause_hi_en(pause_hi_en), .pause_hi_code(pause_hi_code),
      .pause_lo_en(pause_lo_en), .pause_lo_code(pause_lo_code),
      .duty(duty), .running(running), .done(done)
   );

   always #5 clk = ~clk;

   task automatic report;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual %0d cycles, expected fewer than 190000", cycles);
         report();
         $finish;
      end
   end

   function automatic int pause_of(int code);
      return (code > 56) ? 7000 : PAUSE_T[code];
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic write_entry(int idx, int val);
      @(negedge clk);
      tbl_lo_we = 1'b1; tbl_lo_data = val[7:0];
      @(negedge clk);
      tbl_lo_we = 1'b0;
      tbl_hi_we = 1'b1; tbl_val_msb = val[8]; tbl_entry_idx = idx[5:0];
      @(negedge clk);
      tbl_hi_we = 1'b0;
      exp_mem[idx] = val;
   endtask

   task automatic add_visit(int idx, int ticks);
      for (int t = 0; t < ticks; t++) seq_q.push_back(idx);
   endtask

   // expected entry per tick, built pass by pass from the requirements
   task automatic build_seq(int limit);
      int lo, he, s, e, st, d, far_extra, near_extra;
      bit first, sgl;
      seq_q.delete();
      lo = int'(lo_idx);
      he = (lo_idx > hi_idx) ? int'(lo_idx) : int'(hi_idx);
      sgl = (he == lo);
      s  = ramp_up ? lo : he;
      e  = ramp_up ? he : lo;
      st = ramp_up ? 1 : -1;
      d  = STEP_T[step_code];
      far_extra  = ramp_up ? (pause_hi_en ? d * pause_of(pause_hi_code) : 0)
                           : (pause_lo_en ? d * pause_of(pause_lo_code) : 0);
      near_extra = ramp_up ? (pause_lo_en ? d * pause_of(pause_lo_code) : 0)
                           : (pause_hi_en ? d * pause_of(pause_hi_code) : 0);
      first = 1'b1;
      while (seq_q.size() < limit) begin
         int i0;
         i0 = (first || !reverse_en || sgl) ? s : s + st;
         for (int i = i0; i != e; i += st) add_visit(i, d);
         add_visit(e, d + far_extra);
         first = 1'b0;
         if (reverse_en && !sgl) begin
            for (int i = e - st; i != s; i -= st) add_visit(i, d);
            add_visit(s, d + near_extra);
         end
         if (!loop_en) break;
      end
   endtask

   task automatic stop_run(string tag);
      ramp_go = 1'b0;
      @(negedge clk);
      chk(tag, "idle duty", int'(duty), 0);
      chk(tag, "idle running", int'(running), 0);
      chk(tag, "idle done", int'(done), 0);
   endtask

   task automatic run_pattern(string tag, int loop_ticks);
      int total, last;
      build_seq(loop_en ? loop_ticks + 1 : 1);
      total = loop_en ? loop_ticks : seq_q.size() + 3;
      last  = seq_q[seq_q.size() - 1];
      gen_en = 1'b1; ramp_go = 1'b1;
      @(negedge clk);
      chk(tag, "start duty", int'(duty), exp_mem[seq_q[0]]);
      chk(tag, "start running", int'(running), 1);
      for (int k = 1; k <= total; k++) begin
         repeat (3) @(negedge clk);
         tick_1k = 1'b1;
         @(negedge clk);
         tick_1k = 1'b0;
         if (k < seq_q.size()) begin
            chk(tag, "duty", int'(duty), exp_mem[seq_q[k]]);
            chk(tag, "running", int'(running), 1);
            chk(tag, "done", int'(done), 0);
         end else begin
            chk("R10", "held duty", int'(duty), exp_mem[last]);
            chk("R10", "done", int'(done), 1);
            chk("R10", "running", int'(running), 0);
         end
      end
      stop_run("R3");
   endtask

   task automatic set_cfg(int lo, int hi, bit up, bit rev, bit lp, int sc,
                          bit phe, int phc, bit ple, int plc);
      lo_idx = lo[5:0]; hi_idx = hi[5:0]; ramp_up = up; reverse_en = rev;
      loop_en = lp; step_code = sc[3:0];
      pause_hi_en = phe; pause_hi_code = phc[5:0];
      pause_lo_en = ple; pause_lo_code = plc[5:0];
   endtask

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'h5eed_1234);
      for (int i = 0; i < 64; i++) exp_mem[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R3", "reset duty", int'(duty), 0);
      chk("R3", "reset running", int'(running), 0);
      chk("R3", "reset done", int'(done), 0);

      // R1: reset contents read as zero through a one-entry window
      set_cfg(7, 7, 1, 0, 0, 1, 0, 0, 0, 0);
      run_pattern("R1", 0);

      for (int i = 0; i < 64; i++) write_entry(i, int'($urandom % 512));
      write_entry(3, 9'h1a5);
      set_cfg(3, 3, 1, 0, 0, 1, 0, 0, 0, 0);
      run_pattern("R1", 0);

      // R2: staging a byte without the commit leaves entry 5 alone
      @(negedge clk);
      tbl_lo_we = 1'b1; tbl_lo_data = 8'(exp_mem[5] ^ 8'hff);
      @(negedge clk);
      tbl_lo_we = 1'b0;
      set_cfg(5, 5, 1, 0, 0, 2, 0, 0, 0, 0);
      run_pattern("R2", 0);

      // R3: go without generator enable stays idle, ticks included
      gen_en = 1'b0; ramp_go = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); tick_1k = 1'b1;
         @(negedge clk); tick_1k = 1'b0;
         chk("R3", "gated running", int'(running), 0);
         chk("R3", "gated duty", int'(duty), 0);
      end
      ramp_go = 1'b0;

      // directed corner cases
      set_cfg(20, 24, 1, 0, 0, 2, 0, 0, 0, 0);  run_pattern("R5", 0);
      set_cfg(30, 33, 0, 0, 0, 1, 0, 0, 0, 0);  run_pattern("R5", 0);
      set_cfg(40, 43, 1, 1, 0, 1, 0, 0, 0, 0);  run_pattern("R6", 0);
      set_cfg(10, 12, 0, 1, 1, 1, 0, 0, 0, 0);  run_pattern("R7", 30);
      set_cfg(50, 52, 1, 0, 1, 3, 1, 2, 0, 0);  run_pattern("R7", 30);
      set_cfg(1, 3, 1, 1, 0, 2, 1, 1, 1, 3);    run_pattern("R8", 0);
      set_cfg(20, 15, 0, 1, 1, 2, 0, 0, 0, 0);  run_pattern("R11", 10);
      set_cfg(44, 2, 1, 0, 0, 1, 0, 0, 0, 0);   run_pattern("R11", 0);
      set_cfg(9, 9, 1, 0, 0, 15, 0, 0, 0, 0);   run_pattern("R4", 0);
      set_cfg(9, 10, 1, 0, 0, 0, 0, 0, 0, 0);   run_pattern("R4", 0);
      set_cfg(6, 6, 1, 0, 0, 1, 1, 60, 0, 0);   run_pattern("R9", 0);
      set_cfg(6, 6, 0, 0, 0, 1, 0, 0, 1, 36);   run_pattern("R9", 0);

      // R12: commit into the next entry on the same edge as the step
      set_cfg(10, 12, 1, 0, 0, 1, 0, 0, 0, 0);
      gen_en = 1'b1; ramp_go = 1'b1;
      @(negedge clk);
      chk("R12", "start duty", int'(duty), exp_mem[10]);
      begin
         int nv;
         nv = (exp_mem[11] + 137) % 512;
         tbl_lo_we = 1'b1; tbl_lo_data = nv[7:0];
         @(negedge clk);
         tbl_lo_we = 1'b0;
         tick_1k = 1'b1;
         tbl_hi_we = 1'b1; tbl_val_msb = nv[8]; tbl_entry_idx = 6'd11;
         @(negedge clk);
         tick_1k = 1'b0; tbl_hi_we = 1'b0;
         exp_mem[11] = nv;
         chk("R12", "same-edge duty", int'(duty), nv);
      end
      stop_run("R3");

      // constrained random patterns
      for (int r = 0; r < 25; r++) begin
         int lo, hi;
         string tag;
         lo = int'($urandom % 58);
         hi = ($urandom % 6 == 0) ? lo - int'($urandom % 3) - 1 : lo + int'($urandom % 5);
         if (hi < 0) hi = 0;
         set_cfg(lo, hi, 1'($urandom), 1'($urandom), 1'($urandom),
                 int'($urandom % 7), 1'($urandom), int'($urandom % 4),
                 1'($urandom), int'($urandom % 4));
         if (lo > hi) tag = "R11";
         else if (reverse_en) tag = "R6";
         else if (loop_en) tag = "R7";
         else if (pause_hi_en || pause_lo_en) tag = "R8";
         else tag = "R5";
         run_pattern(tag, 40);
      end

      report();
      $finish;
   end
endmodule